// File: doc/BRIEF.md
# Serial Presence-Detect EEPROM Slave

This block models the small 256-byte configuration memory that sits on a memory module and is read by the host over a two-wire I2C bus. It samples SCL and SDA with a fast local clock, detects START and STOP, and pulls SDA low through an open-drain enable when it acknowledges or returns a zero data bit. Three strap inputs select one of eight bus addresses, so several modules can share one bus.

The lower 128 bytes come out of reset holding a module identity pattern with a checksum byte. The upper 128 bytes are a user area that reads as erased. The host can write single bytes or pages within a 16-byte page. It can read from the current word address, from a chosen address through a repeated START, or sequentially. Every STOP that ends a write starts a program cycle of fixed length. During that cycle the block stays off the bus and shows a busy flag.

Controller states: IDLE (waiting for START), ADDR (shifting the address byte), ADDR_ACK, WORD (shifting the word address), WORD_ACK, WRITE (shifting a data byte), WRITE_ACK, READ (shifting a byte out), READ_ACK (master acknowledge slot) and PROG (program cycle). Transitions:
- Any state except PROG goes to ADDR on START. On STOP it goes to PROG if data was written in the transaction, and to IDLE otherwise.
- ADDR goes to ADDR_ACK on a matching address and to IDLE on a mismatch.
- ADDR_ACK goes to READ or WORD according to the direction bit.
- WORD goes to WORD_ACK, then to WRITE.
- WRITE goes to WRITE_ACK and back to WRITE.
- READ goes to READ_ACK. READ_ACK goes back to READ on a master ACK and to IDLE on a NACK.
- PROG goes to IDLE when the timer expires.

Top module: `spd_eeprom`

## Requirements
- R1: After reset, sda_pull is 0 and busy is 0.
- R2: The block acknowledges (pulls SDA low in the ninth clock) only an address byte whose bits 7:4 are 1010 and bits 3:1 equal strap[2:0]. Bit 0 set means read. On a mismatch it stays silent for the rest of the transaction, and any bytes sent are not stored.
- R3: Out of reset, byte i for i in 0..127 except 63 holds (37*i+5) mod 256. Byte 63 holds the low 8 bits of the sum of bytes 0..62. Bytes 128..255 hold 0xFF.
- R4: A write transaction is the address byte with bit 0 clear, then a word address, then data bytes. Each byte is acknowledged, and each data byte is stored at the current word address.
- R5: During a write, the word address increments after each data byte within its 16-byte page: bits 7:4 are kept and bits 3:0 wrap from 15 to 0.
- R6: During a read, the word address increments modulo 256 after every byte sent. Bytes keep coming while the master acknowledges, and the read ends on a master NACK followed by STOP.
- R7: A write of a word address, then a repeated START and a read address byte, returns data starting at that word address.
- R8: A STOP that ends a transaction in which at least one data byte was written raises busy for exactly PROG_CYCLES clock cycles. A STOP that ends a read does not raise busy.
- R9: While busy is high the block never pulls SDA and acknowledges no address.
- R10: The factory area (bytes 0..127) is writable in the same way as the user area.
- R11: sda_pull changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock |
| sda_in | input | 1 | Bus data as seen on the wire |
| strap | input | 3 | Address strap, low three address bits |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| busy | output | 1 | High during the program cycle |

## Verification
A sequential read of all 256 bytes after reset compares every location with the computed identity pattern, the checksum and the erased user area. A following current-address read shows that the address wrapped from 255 to 0. A sweep over all eight strap values against all eight address values tells matching from non-matching addresses. Writes that start near a page end, and reads that start near the top of the array, show the page wrap of writes apart from the full-array wrap of reads. Writes into the factory area, addressing attempts during the program cycle, a silent mismatched write and a read-only STOP together separate correct program-cycle behaviour from spurious or missing busy windows.

// File: rtl/spd_pkg.sv
package spd_pkg;

    localparam logic [3:0] DEV_ID     = 4'b1010;
    localparam int         FACT_MUL   = 37;
    localparam int         FACT_ADD   = 5;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_ADDR_ACK, S_WORD, S_WORD_ACK,
        S_WRITE, S_WRITE_ACK, S_READ, S_READ_ACK, S_PROG
    } spd_state_t;

    // identity pattern held in the factory area
    function automatic logic [7:0] factory_byte(input int idx);
        logic [31:0] t;
        t = 32'(idx * FACT_MUL + FACT_ADD);
        return t[7:0];
    endfunction

    // low 8 bits of the sum of the first n pattern bytes
    function automatic logic [7:0] factory_sum(input int n);
        logic [7:0] s;
        s = 8'h00;
        for (int k = 0; k < n; k++) s = s + factory_byte(k);
        return s;
    endfunction

endpackage

// File: rtl/spd_bus_sense.sv
module spd_bus_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [1:0] scl_m, sda_m;
    logic       scl_p, sda_p;
    logic       scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 2'b11;
            sda_m <= 2'b11;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= {scl_m[0], scl_in};
            sda_m <= {sda_m[0], sda_in};
            scl_p <= scl_m[1];
            sda_p <= sda_m[1];
        end
    end

    assign scl_s     = scl_m[1];
    assign sda_s     = sda_m[1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_evt = scl_s & scl_p & ~sda_s & sda_p;
    assign stop_evt  = scl_s & scl_p & sda_s & ~sda_p;
endmodule

// File: rtl/spd_array.sv
module spd_array #(
    parameter int MEM_BYTES     = 256,
    parameter int FACTORY_BYTES = 128,
    parameter int CSUM_INDEX    = 63,
    localparam int AW           = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam logic [7:0] CSUM = spd_pkg::factory_sum(CSUM_INDEX);

    logic [7:0] mem [MEM_BYTES];

    function automatic logic [7:0] init_byte(input int i);
        if (i >= FACTORY_BYTES) return 8'hFF;
        if (i == CSUM_INDEX)    return CSUM;
        return spd_pkg::factory_byte(i);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= init_byte(i);
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/spd_prog_timer.sv
module spd_prog_timer #(
    parameter int  PROG_CYCLES = 500000,
    localparam int CW          = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic running
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign running = (cnt != '0);
endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom #(
    parameter int PROG_CYCLES   = 500000,
    parameter int MEM_BYTES     = 256,
    parameter int PAGE_BYTES    = 16,
    parameter int FACTORY_BYTES = 128,
    parameter int CSUM_INDEX    = 63
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    output logic       sda_pull,
    output logic       busy
);
    import spd_pkg::*;

    localparam int AW = $clog2(MEM_BYTES);
    localparam int PW = $clog2(PAGE_BYTES);

    logic sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic mem_we, prog_load;
    logic [7:0] rdata, byte_in;

    spd_state_t st_q, st_d;
    logic [2:0]    bit_q, bit_d;
    logic [7:0]    sh_q, sh_d;
    logic [AW-1:0] addr_q, addr_d;
    logic          drv_q, drv_d, ackd_q, ackd_d, rw_q, rw_d, wrote_q, wrote_d;

    spd_bus_sense u_sense (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    spd_array #(
        .MEM_BYTES(MEM_BYTES), .FACTORY_BYTES(FACTORY_BYTES), .CSUM_INDEX(CSUM_INDEX)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .addr(addr_q),
        .wdata(byte_in), .rdata(rdata)
    );

    spd_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(prog_load), .running(busy)
    );

    assign byte_in = {sh_q[6:0], sda_s};

    // next-state and datapath decisions
    always_comb begin
        st_d = st_q;  bit_d = bit_q;  sh_d = sh_q;  addr_d = addr_q;
        drv_d = drv_q; ackd_d = ackd_q; rw_d = rw_q; wrote_d = wrote_q;
        mem_we = 1'b0; prog_load = 1'b0;
        if (st_q == S_PROG) begin
            if (!busy) st_d = S_IDLE;
        end else if (stop_evt) begin
            drv_d     = 1'b0;
            prog_load = wrote_q;
            st_d      = wrote_q ? S_PROG : S_IDLE;
            wrote_d   = 1'b0;
        end else if (start_evt) begin
            st_d  = S_ADDR;
            bit_d = '0;
            drv_d = 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: ;
                S_ADDR, S_WORD, S_WRITE: begin
                    if (scl_rise) begin
                        sh_d   = byte_in;
                        bit_d  = bit_q + 3'd1;
                        ackd_d = 1'b0;
                        if (bit_q == 3'd7) begin
                            if (st_q == S_ADDR) begin
                                if (byte_in[7:1] == {DEV_ID, strap}) begin
                                    rw_d = byte_in[0];
                                    st_d = S_ADDR_ACK;
                                end else begin
                                    st_d = S_IDLE;
                                end
                            end else if (st_q == S_WORD) begin
                                addr_d = byte_in[AW-1:0];
                                st_d   = S_WORD_ACK;
                            end else begin
                                mem_we  = 1'b1;
                                addr_d  = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
                                wrote_d = 1'b1;
                                st_d    = S_WRITE_ACK;
                            end
                        end
                    end
                end
                S_ADDR_ACK, S_WORD_ACK, S_WRITE_ACK: begin
                    if (scl_fall) begin
                        if (!ackd_q) begin
                            drv_d  = 1'b1;
                            ackd_d = 1'b1;
                        end else begin
                            drv_d = 1'b0;
                            bit_d = '0;
                            if (st_q == S_ADDR_ACK && rw_q) begin
                                st_d  = S_READ;
                                sh_d  = rdata;
                                drv_d = ~rdata[7];
                            end else if (st_q == S_ADDR_ACK) begin
                                st_d = S_WORD;
                            end else begin
                                st_d = S_WRITE;
                            end
                        end
                    end
                end
                S_READ: begin
                    if (scl_rise) begin
                        bit_d = bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            st_d   = S_READ_ACK;
                            ackd_d = 1'b0;
                            addr_d = addr_q + 1'b1;
                        end
                    end else if (scl_fall) begin
                        drv_d = ~sh_q[6];
                        sh_d  = {sh_q[6:0], 1'b0};
                    end
                end
                S_READ_ACK: begin
                    if (scl_rise) begin
                        if (sda_s) st_d = S_IDLE;
                        else       ackd_d = 1'b1;
                    end else if (scl_fall) begin
                        if (!ackd_q) begin
                            drv_d = 1'b0;
                        end else begin
                            st_d  = S_READ;
                            sh_d  = rdata;
                            drv_d = ~rdata[7];
                            bit_d = '0;
                        end
                    end
                end
                default: st_d = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0; sh_q <= '0; addr_q <= '0;
            drv_q <= 1'b0; ackd_q <= 1'b0; rw_q <= 1'b0; wrote_q <= 1'b0;
        end else begin
            bit_q <= bit_d; sh_q <= sh_d; addr_q <= addr_d;
            drv_q <= drv_d; ackd_q <= ackd_d; rw_q <= rw_d; wrote_q <= wrote_d;
        end
    end

    assign sda_pull = drv_q;
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk #(
    parameter int PROG_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_pull,
    input logic busy,
    input logic stop_evt
);
    localparam int CW = $clog2(PROG_CYCLES + 2);
    logic [CW-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_run <= '0;
        else if (busy) busy_run <= busy_run + 1'b1;
        else           busy_run <= '0;
    end

    AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull); // R9
    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !$past(scl_in)); // R11
    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_evt)); // R8
    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < CW'(PROG_CYCLES))); // R8
endmodule

bind spd_eeprom spd_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_pull(sda_pull),
    .busy(busy), .stop_evt(stop_evt)
);

// File: tb/spd_eeprom_bench.sv
module spd_eeprom_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam int PROG       = 200;
    localparam logic [2:0] MY_STRAP = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
    logic [2:0] strap = MY_STRAP;
    logic sda_pull, busy, sda_line;
    int tests = 0, fails = 0, busy_len = 0;
    logic [7:0] model [256];

    assign sda_line = m_sda & ~sda_pull;
    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (busy) busy_len++;

    spd_eeprom #(.PROG_CYCLES(PROG)) u_spd_eeprom (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .strap(strap), .sda_pull(sda_pull), .busy(busy)
    );

    task automatic w(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); m_sda = 1'b0; w(Q); scl = 1'b0; w(Q);
    endtask
    task automatic bus_stop();
        m_sda = 1'b0; w(Q); scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
    endtask
    task automatic put_bit(input logic b);
        m_sda = b; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    endtask
    task automatic get_bit(output logic b);
        m_sda = 1'b1; w(Q); scl = 1'b1; w(Q); b = sda_line; w(Q); scl = 1'b0; w(Q);
    endtask
    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask
    task automatic get_byte(output logic [7:0] d, input logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
        put_bit(~ack);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * PROG && busy; i++) w(1);
    endtask

    // write n bytes (packed, first byte in [7:0]) starting at word address a
    task automatic write_seq(input logic [7:0] a, input logic [23:0] d, input int n, input string req);
        logic ack;
        bus_start();
        put_byte({4'hA, MY_STRAP, 1'b0}, ack); chk(ack, req, ack, 1);
        put_byte(a, ack);                     chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            put_byte(d[8*k +: 8], ack);       chk(ack, req, ack, 1);
            model[{a[7:4], 4'(a[3:0] + k)}] = d[8*k +: 8];
        end
        busy_len = 0;
        bus_stop();
    endtask

    task automatic random_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] d;
        bus_start();
        put_byte({4'hA, MY_STRAP, 1'b0}, ack); chk(ack, "R7", ack, 1);
        put_byte(a, ack);                     chk(ack, "R7", ack, 1);
        bus_start();
        put_byte({4'hA, MY_STRAP, 1'b1}, ack); chk(ack, "R7", ack, 1);
        for (int k = 0; k < n; k++) begin
            get_byte(d, k != n - 1);
            chk(d == model[8'(a + k)], req, d, model[8'(a + k)]);
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] d;
        logic [7:0] sum;
        sum = 8'h00;
        for (int i = 0; i < 256; i++) begin
            model[i] = (i < 128) ? 8'((37 * i + 5) % 256) : 8'hFF;
            if (i < 63) sum = sum + model[i];
        end
        model[63] = sum;

        w(5); rst_n = 1'b1; w(3);
        chk(sda_pull == 1'b0, "R1", sda_pull, 0);
        chk(busy == 1'b0, "R1", busy, 0);

        // R3 R6 R7: full sequential read of the preloaded array
        random_read(8'h00, 256, "R3");
        chk(busy == 1'b0, "R8", busy, 0);

        // R6: current-address read after 256 bytes wraps to byte 0
        bus_start();
        put_byte({4'hA, MY_STRAP, 1'b1}, ack); chk(ack, "R6", ack, 1);
        get_byte(d, 1'b0); chk(d == model[0], "R6", d, model[0]);
        bus_stop();

        // R2: sweep every strap against every address
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            for (int a = 0; a < 8; a++) begin
                bus_start();
                put_byte({4'hA, 3'(a), 1'b1}, ack);
                chk(ack == (a == s), "R2", ack, (a == s));
                if (ack) get_byte(d, 1'b0);
                bus_stop();
            end
        end
        strap = MY_STRAP;

        // R2: mismatched write is not acknowledged and not stored
        bus_start();
        put_byte({4'hA, 3'd2, 1'b0}, ack); chk(!ack, "R2", ack, 0);
        put_byte(8'h00, ack);             chk(!ack, "R2", ack, 0);
        put_byte(8'hEE, ack);             chk(!ack, "R2", ack, 0);
        bus_stop();
        w(10); chk(busy == 1'b0, "R2", busy, 0);
        random_read(8'h00, 1, "R2");

        // R4 R8: single byte write, busy window length
        write_seq(8'h90, 24'h000010, 1, "R4");
        chk(busy == 1'b1, "R8", busy, 1);
        wait_idle(); w(2);
        chk(busy_len == PROG, "R8", busy_len, PROG);
        random_read(8'h90, 1, "R4");

        // R5: page write wrapping inside the 16-byte page
        write_seq(8'h8E, 24'h332211, 3, "R5");
        wait_idle(); w(2);
        random_read(8'h80, 1, "R5");
        random_read(8'h8E, 2, "R5");
        random_read(8'h81, 1, "R5");

        // R10: factory area writable
        write_seq(8'h05, 24'h00005A, 1, "R10");
        wait_idle(); w(2);
        random_read(8'h04, 3, "R10");

        // R9: address refused during the program cycle
        write_seq(8'hC0, 24'h0000A5, 1, "R4");
        bus_start();
        put_byte({4'hA, MY_STRAP, 1'b1}, ack); chk(!ack, "R9", ack, 0);
        chk(busy == 1'b1, "R9", busy, 1);
        bus_stop();
        wait_idle(); w(2);
        random_read(8'hC0, 1, "R9");

        // R6: sequential read crossing 255 -> 0
        random_read(8'hFE, 3, "R6");
        w(10); chk(busy == 1'b0, "R8", busy, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule